// File: doc/BRIEF.md
# Warp Lane Sequencer

This block issues one instruction for a 32-thread warp onto a smaller set of physical execution lanes. The warp width is fixed at 32; the lane count is a parameter and may be 8 or 16. The sequencer runs the warp as 32/LANES back-to-back passes, one pass per clock. In each pass every lane is given a thread index and a result.

A per-thread active mask comes with each instruction. A thread whose mask bit is clear still has its lane slot, but the lane strobe stays low, so that thread changes no state. Divergent if/else code uses this mask: the same warp is issued once for each path, each time with the complementary mask. A partial last warp uses it the same way, with its missing threads masked off.

The lane datapath here is a stand-in. Each lane either adds its two operands or passes the first operand through. The operands of all 32 threads are latched when the instruction is accepted. After the final pass the block gives a one-cycle done pulse.

Top module: `warp_lane_seq`

## Requirements
- R1: `issue_ready` is high exactly when the sequencer is idle. An instruction is accepted on a clock edge where `issue_valid` and `issue_ready` are both high. An `issue_valid` raised while busy is ignored.
- R2: An accepted instruction runs as 32/LANES consecutive passes. Pass 0 is visible in the cycle after acceptance.
- R3: In pass k, lane j carries thread index k*LANES+j on its 5-bit field of `lane_tid`. Lane j occupies bits [5j+4:5j].
- R4: `lane_vld[j]` equals mask bit (k*LANES+j) of the accepted mask, where bit i belongs to thread i. All strobes are low while idle.
- R5: When `issue_op` is 0, a lane result is (a+b) mod 2^DW. When `issue_op` is 1, it is a. Thread i's operands sit at bits [i*DW +: DW] of `issue_opa` and `issue_opb`.
- R6: `done` is high for exactly one cycle, the cycle after the final pass. This also holds when the mask is all zeros.
- R7: Over one instruction, every thread whose mask bit is set is strobed exactly once, and no other thread is strobed.
- R8: After reset, `issue_ready` is 1, `done` is 0 and all lane strobes are 0.
- R9: Operands, mask and op are sampled only at acceptance. Changing these inputs afterwards has no effect on the running instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Sequencer idle, can accept |
| issue_op | input | 1 | 0: add, 1: pass first operand |
| issue_mask | input | 32 | Per-thread active mask |
| issue_opa | input | 32*DW | First operand per thread |
| issue_opb | input | 32*DW | Second operand per thread |
| lane_vld | output | LANES | Per-lane operation strobe |
| lane_tid | output | LANES*5 | Thread index per lane |
| lane_res | output | LANES*DW | Result per lane |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets four corner cases:
- An all-zero mask, where a design that skips done for an empty warp would hang its issuer.
- A tail mask covering only threads 0 to 19, where wrong index arithmetic would strobe threads past the tail or drop the ones beside the last pass boundary.
- A complementary pair of divergent masks, which shows whether the union covers the warp exactly once. A mask misrouted by lane would duplicate some threads or lose others.
- Inputs changed, and a second `issue_valid` raised, in the middle of an instruction. These show whether the sequencer re-samples its operands or accepts a new instruction while busy; either fault corrupts results or cuts the pass sequence short.

// File: rtl/warp_lane_seq.sv
module warp_lane_seq #(
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  output logic                issue_ready,
  input  logic                issue_op,
  input  logic [31:0]         issue_mask,
  input  logic [32*DW-1:0]    issue_opa,
  input  logic [32*DW-1:0]    issue_opb,
  output logic [LANES-1:0]    lane_vld,
  output logic [LANES*5-1:0]  lane_tid,
  output logic [LANES*DW-1:0] lane_res,
  output logic                done
);
  localparam int WARP   = 32;
  localparam int TW     = 5;
  localparam int PASSES = WARP / LANES;
  localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;

  logic              busy;
  logic [PW-1:0]     pass_q;
  logic [WARP-1:0]   mask_q;
  logic [WARP*DW-1:0] opa_q, opb_q;
  logic              op_q;
  logic              done_q;
  logic              accept;

  assign issue_ready = !busy;
  assign accept      = issue_valid && !busy;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pass_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        pass_q <= '0;
      end else if (busy) begin
        if (pass_q == PW'(PASSES - 1)) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          pass_q <= pass_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mask_q <= issue_mask;
      opa_q  <= issue_opa;
      opb_q  <= issue_opb;
      op_q   <= issue_op;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [TW-1:0] tid;
    logic [DW-1:0] a, b;
    assign tid = TW'(pass_q) * TW'(LANES) + TW'(j);
    assign a   = opa_q[tid*DW +: DW];
    assign b   = opb_q[tid*DW +: DW];
    assign lane_tid[j*TW +: TW] = tid;
    assign lane_vld[j]          = busy && mask_q[tid];
    assign lane_res[j*DW +: DW] = op_q ? a : a + b;
  end
endmodule

module warp_lane_seq_chk #(
  parameter int LANES = 8,
  parameter int DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                issue_valid,
  input logic                issue_ready,
  input logic [LANES-1:0]    lane_vld,
  input logic [LANES*5-1:0]  lane_tid,
  input logic                done
);
  logic [4:0] tid0;
  assign tid0 = lane_tid[4:0];

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ready |-> lane_vld == '0);

  p_accept_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> (!issue_ready && tid0 == 5'd0));

  p_pass_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_ready && $past(!issue_ready)) |-> tid0 == $past(tid0) + 5'(LANES));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (issue_ready && $past(!issue_ready)));

  for (genvar j = 1; j < LANES; j++) begin : g_tidchk
    p_lane_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_ready |-> lane_tid[j*5 +: 5] == tid0 + 5'(j));
  end
endmodule

bind warp_lane_seq warp_lane_seq_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
  .lane_vld(lane_vld), .lane_tid(lane_tid), .done(done)
);

// File: tb/tb_warp_lane_seq.sv
module tb_warp_lane_seq;
  localparam int LANES = 8;
  localparam int DW    = 16;
  localparam int P     = 32 / LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic issue_ready;
  logic issue_op = 1'b0;
  logic [31:0] issue_mask = '0;
  logic [32*DW-1:0] issue_opa = '0;
  logic [32*DW-1:0] issue_opb = '0;
  logic [LANES-1:0] lane_vld;
  logic [LANES*5-1:0] lane_tid;
  logic [LANES*DW-1:0] lane_res;
  logic done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  warp_lane_seq #(.LANES(LANES), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_mask(issue_mask), .issue_opa(issue_opa),
    .issue_opb(issue_opb), .lane_vld(lane_vld), .lane_tid(lane_tid),
    .lane_res(lane_res), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] opa_of(input int i, input logic [15:0] s);
    return DW'(i * 37 + 5) ^ DW'(s);
  endfunction
  function automatic logic [DW-1:0] opb_of(input int i, input logic [15:0] s);
    return DW'(s) * DW'(3) + DW'(i * 4099);
  endfunction

  task automatic load_ops(input logic [15:0] s);
    for (int i = 0; i < 32; i++) begin
      issue_opa[i*DW +: DW] = opa_of(i, s);
      issue_opb[i*DW +: DW] = opb_of(i, s);
    end
  endtask

  task automatic run(input logic [31:0] m, input logic op, input logic [15:0] s, input bit poke);
    bit seen[32];
    int dups = 0;
    int wrong = 0;
    for (int i = 0; i < 32; i++) seen[i] = 1'b0;
    @(negedge clk);
    load_ops(s);
    issue_mask = m;
    issue_op = op;
    issue_valid = 1'b1;
    @(posedge clk);
    #1;
    issue_valid = 1'b0;
    load_ops(s ^ 16'h5a5a);
    issue_mask = ~m;
    issue_op = ~op;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      chk(issue_ready == 1'b0, "R1 busy", issue_ready, 0);
      chk(done == 1'b0, "R6 early done", done, 0);
      issue_valid = poke && (k == 0);
      for (int j = 0; j < LANES; j++) begin
        int t;
        logic [DW-1:0] a, b, e;
        t = k * LANES + j;
        chk(lane_tid[j*5 +: 5] == 5'(t), "R2 R3 tid", lane_tid[j*5 +: 5], t);
        chk(lane_vld[j] == m[t], "R4 strobe", lane_vld[j], m[t]);
        if (lane_vld[j]) begin
          if (seen[t]) dups++;
          seen[t] = 1'b1;
          a = opa_of(t, s);
          b = opb_of(t, s);
          e = op ? a : a + b;
          chk(lane_res[j*DW +: DW] == e, "R5 R9 result", lane_res[j*DW +: DW], e);
        end
      end
    end
    issue_valid = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, "R6 done", done, 1);
    chk(issue_ready == 1'b1, "R1 idle", issue_ready, 1);
    chk(lane_vld == '0, "R4 idle strobes", lane_vld, 0);
    for (int i = 0; i < 32; i++) if (seen[i] != m[i]) wrong++;
    chk(wrong == 0 && dups == 0, "R7 coverage", 64'(wrong * 256 + dups), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 pulse width", done, 0);
    chk(lane_vld == '0, "R1 busy issue ignored", lane_vld, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(issue_ready == 1'b1, "R8 ready", issue_ready, 1);
    chk(done == 1'b0, "R8 done", done, 0);
    chk(lane_vld == '0, "R8 strobes", lane_vld, 0);
  endtask

  task automatic t_full;      run(32'hFFFF_FFFF, 1'b0, 16'h1234, 1'b0); endtask
  task automatic t_empty;     run(32'h0000_0000, 1'b0, 16'h0042, 1'b0); endtask
  task automatic t_tail;      run(32'h000F_FFFF, 1'b1, 16'hBEEF, 1'b0); endtask
  task automatic t_diverge;
    run(32'hA5C3_0F96, 1'b0, 16'h0777, 1'b0);
    run(32'h5A3C_F069, 1'b1, 16'h0777, 1'b0);
  endtask
  task automatic t_busy_poke; run(32'h8000_0001, 1'b0, 16'hFFFF, 1'b1); endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full();
    t_empty();
    t_tail();
    t_diverge();
    t_busy_poke();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule